// File: doc/BRIEF.md
# Dual-queue converter interrupt flag controller

This block sits beside an analog-to-digital converter that runs two command queues. For each queue it keeps two sticky status flags: one marking that the queue has finished its last command, and one marking that a command carrying a pause mark has finished. The converter reports each of these four events with a single-cycle strobe. Each flag has its own enable, and any enabled, set flag drives an interrupt request toward the processor. The request stays asserted until software clears the flag.

Software clears a flag in two steps. It reads the status register, then writes zero to the flag bits it wants to clear. A flag is cleared only if that read saw it set and no new event for it arrived after the read. This closes the race in which an event is lost between servicing and clearing. Each queue has its own request level. Each of the four sources returns its own vector number on acknowledge. The vector is made of a software-written base and a two-bit source index. The level, vector base and per-queue levels sit in a configuration register that only supervisor accesses may reach.

Register map (byte-free word addresses): 0 = status, 1 = enables, 2 = configuration, 3 = unused.

Top module: `qdi_irq_ctrl`

## Requirements
- R1: Event strobe bit i (0 = queue 1 done, 1 = queue 1 pause, 2 = queue 2 done, 3 = queue 2 pause) sets flag i at the next clock edge. Flag i reads back at bit i of the status register (address 0), and the other status bits read zero.
- R2: The enable register (address 1) holds four enable bits in bits 3:0 and may be accessed in any mode. irq_req is high exactly while some flag and its enable bit are both set.
- R3: A zero written to a status bit does not clear a flag that was not seen set by a status read since its last event.
- R4: After a status read that saw flag i set, writing 0 to bit i clears it at the next edge. Writing 1 to bit i leaves it set.
- R5: An event for flag i arriving after the arming read, including in the same cycle as the zero write, keeps flag i set and requires a fresh read before it can be cleared.
- R6: While irq_ack and irq_req are both high, irq_vector = {base, idx}, where idx is the lowest pending (flag and enable) source index. Otherwise irq_vector is zero.
- R7: irq_level is the queue 1 level for sources 0 and 1 and the queue 2 level for sources 2 and 3, chosen by the reported source. It is zero while irq_req is low.
- R8: The configuration register (address 2) is reached only when bus_sup is high. A user-mode read returns zero, and a user-mode write changes nothing.
- R9: Configuration layout: bits 2:0 are the queue 1 level, bits 6:4 the queue 2 level, and bits 15:10 the vector base. Bits 3, 7, 9 and 8 read zero and ignore writes, so writing 0xFFFF reads back 0xFC77. Address 3 reads zero.
- R10: After reset, all flags, enables and configuration fields are zero, and irq_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_i | input | 4 | Event strobes, one per source |
| bus_rd | input | 1 | Register read strobe |
| bus_wr | input | 1 | Register write strobe |
| bus_sup | input | 1 | Supervisor qualifier for the access |
| bus_addr | input | ADDR_W | Register word address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid in the cycle of bus_rd |
| irq_req | output | 1 | Interrupt request |
| irq_level | output | LVL_W | Request level of the reported source |
| irq_ack | input | 1 | Interrupt acknowledge |
| irq_vector | output | VEC_W | Vector number during acknowledge |

## Verification
Every cycle, the assertions check four things. Events always land in their flags. A flag that no read has armed cannot drop. irq_req matches the pending set. The acknowledged vector names the lowest pending source. They also check that user-mode accesses neither reveal nor change the configuration. The clear race needs ordered sequences of read, event and write, as does arming, disarming and re-arming a flag. The reserved-bit readback and the priority between queues with different levels also need ordered sequences. These can only be shown by the bench's directed cases and its random traffic compared against the model.

// File: rtl/qdi_pkg.sv
package qdi_pkg;
   localparam int NSRC  = 4;
   localparam int NQ    = 2;
   localparam int IDX_W = 2;

   typedef enum logic [1:0] {
      SRC_Q1_DONE  = 2'd0,
      SRC_Q1_PAUSE = 2'd1,
      SRC_Q2_DONE  = 2'd2,
      SRC_Q2_PAUSE = 2'd3
   } src_e;

   localparam int REG_STATUS = 0;
   localparam int REG_ENABLE = 1;
   localparam int REG_CONFIG = 2;
endpackage

// File: rtl/qdi_flag_cell.sv
// One sticky status flag with its read-while-set marker.
module qdi_flag_cell (
   input  logic clk,
   input  logic rst_n,
   input  logic evt_i,
   input  logic rd_stat_i,
   input  logic clr_i,
   output logic flag_o,
   output logic armed_o
);
   logic flag_q, arm_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         flag_q <= 1'b0;
         arm_q  <= 1'b0;
      end else begin
         if (evt_i)
            flag_q <= 1'b1;
         else if (clr_i && arm_q)
            flag_q <= 1'b0;

         if (evt_i)
            arm_q <= 1'b0;
         else if (rd_stat_i && flag_q)
            arm_q <= 1'b1;
         else if (clr_i && arm_q)
            arm_q <= 1'b0;
      end
   end

   assign flag_o  = flag_q;
   assign armed_o = arm_q;
endmodule

// File: rtl/qdi_cfg_regs.sv
// Enable register and supervisor-only configuration word.
module qdi_cfg_regs #(
   parameter int DATA_W = 16,
   parameter int NSRC   = 4,
   parameter logic [DATA_W-1:0] CFG_MASK = '1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              en_wr_i,
   input  logic              cfg_wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [NSRC-1:0]   en_o,
   output logic [DATA_W-1:0] cfg_o
);
   logic [NSRC-1:0]   en_q;
   logic [DATA_W-1:0] cfg_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q  <= '0;
         cfg_q <= '0;
      end else begin
         if (en_wr_i)
            en_q <= wdata_i[NSRC-1:0];
         if (cfg_wr_i)
            cfg_q <= wdata_i & CFG_MASK;
      end
   end

   assign en_o  = en_q;
   assign cfg_o = cfg_q;
endmodule

// File: rtl/qdi_irq_arb.sv
// Lowest-index pending source selection, level and vector formation.
module qdi_irq_arb #(
   parameter int NSRC  = 4,
   parameter int NQ    = 2,
   parameter int IDX_W = 2,
   parameter int LVL_W = 3,
   parameter int VEC_W = 8,
   localparam int BASE_W = VEC_W - IDX_W,
   localparam int PER_Q  = NSRC / NQ
) (
   input  logic [NSRC-1:0]           pend_i,
   input  logic [NQ-1:0][LVL_W-1:0]  lvl_i,
   input  logic [BASE_W-1:0]         base_i,
   input  logic                      ack_i,
   output logic                      req_o,
   output logic [LVL_W-1:0]          level_o,
   output logic [VEC_W-1:0]          vector_o
);
   logic [IDX_W-1:0] sel;
   logic [NQ-1:0]    q_hit;

   always_comb begin
      sel = '0;
      for (int i = NSRC - 1; i >= 0; i--)
         if (pend_i[i])
            sel = IDX_W'(i);
   end

   assign req_o = |pend_i;

   for (genvar q = 0; q < NQ; q++) begin : g_qsel
      assign q_hit[q] = (32'(sel) / PER_Q) == q;
   end

   always_comb begin
      level_o = '0;
      for (int q = 0; q < NQ; q++)
         if (req_o && q_hit[q])
            level_o = lvl_i[q];
   end

   assign vector_o = (ack_i && req_o) ? {base_i, sel} : '0;
endmodule

// File: rtl/qdi_irq_ctrl.sv
module qdi_irq_ctrl #(
   parameter int DATA_W = 16,
   parameter int LVL_W  = 3,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [3:0]        evt_i,
   input  logic              bus_rd,
   input  logic              bus_wr,
   input  logic              bus_sup,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_req,
   output logic [LVL_W-1:0]  irq_level,
   input  logic              irq_ack,
   output logic [VEC_W-1:0]  irq_vector
);
   import qdi_pkg::*;

   localparam int BASE_W   = VEC_W - IDX_W;
   localparam int BASE_LSB = DATA_W - BASE_W;
   localparam int LVL2_LSB = 4;
   localparam logic [DATA_W-1:0] LVL_ONES = DATA_W'((1 << LVL_W) - 1);
   localparam logic [DATA_W-1:0] CFG_MASK =
      LVL_ONES | (LVL_ONES << LVL2_LSB) |
      (DATA_W'((1 << BASE_W) - 1) << BASE_LSB);

   if (LVL_W < 1 || LVL_W > 4) begin : g_bad_lvl
      $error("LVL_W must be 1..4");
   end
   if (VEC_W <= IDX_W || VEC_W > 16) begin : g_bad_vec
      $error("VEC_W must be 3..16");
   end
   if (DATA_W > 32 || BASE_LSB < 2 * LVL2_LSB) begin : g_bad_data
      $error("DATA_W too narrow for configuration layout");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("ADDR_W must be at least 2");
   end

   logic sel_stat, sel_en, sel_cfg;
   assign sel_stat = bus_addr == ADDR_W'(REG_STATUS);
   assign sel_en   = bus_addr == ADDR_W'(REG_ENABLE);
   assign sel_cfg  = bus_addr == ADDR_W'(REG_CONFIG);

   logic [NSRC-1:0] flags_q, armed_q, enables;
   logic [DATA_W-1:0] cfg_word;

   for (genvar i = 0; i < NSRC; i++) begin : g_flag
      qdi_flag_cell u_cell (
         .clk       (clk),
         .rst_n     (rst_n),
         .evt_i     (evt_i[i]),
         .rd_stat_i (bus_rd && sel_stat),
         .clr_i     (bus_wr && sel_stat && !bus_wdata[i]),
         .flag_o    (flags_q[i]),
         .armed_o   (armed_q[i])
      );
   end

   qdi_cfg_regs #(
      .DATA_W   (DATA_W),
      .NSRC     (NSRC),
      .CFG_MASK (CFG_MASK)
   ) u_cfg (
      .clk      (clk),
      .rst_n    (rst_n),
      .en_wr_i  (bus_wr && sel_en),
      .cfg_wr_i (bus_wr && sel_cfg && bus_sup),
      .wdata_i  (bus_wdata),
      .en_o     (enables),
      .cfg_o    (cfg_word)
   );

   logic [NQ-1:0][LVL_W-1:0] q_lvl;
   assign q_lvl[0] = cfg_word[LVL_W-1:0];
   assign q_lvl[1] = cfg_word[LVL2_LSB +: LVL_W];

   qdi_irq_arb #(
      .NSRC  (NSRC),
      .NQ    (NQ),
      .IDX_W (IDX_W),
      .LVL_W (LVL_W),
      .VEC_W (VEC_W)
   ) u_arb (
      .pend_i   (flags_q & enables),
      .lvl_i    (q_lvl),
      .base_i   (cfg_word[BASE_LSB +: BASE_W]),
      .ack_i    (irq_ack),
      .req_o    (irq_req),
      .level_o  (irq_level),
      .vector_o (irq_vector)
   );

   always_comb begin
      bus_rdata = '0;
      if (bus_rd) begin
         if (sel_stat)
            bus_rdata = DATA_W'(flags_q);
         else if (sel_en)
            bus_rdata = DATA_W'(enables);
         else if (sel_cfg && bus_sup)
            bus_rdata = cfg_word;
      end
   end
endmodule

// File: rtl/qdi_irq_checker.sv
module qdi_irq_checker #(
   parameter int DATA_W = 16,
   parameter int LVL_W  = 3,
   parameter int VEC_W  = 8,
   parameter int ADDR_W = 2,
   parameter logic [DATA_W-1:0] CFG_MASK = '1
) (
   input logic              clk,
   input logic              rst_n,
   input logic [3:0]        evt_i,
   input logic [3:0]        flags,
   input logic [3:0]        armed,
   input logic [3:0]        enables,
   input logic              bus_rd,
   input logic              bus_wr,
   input logic              bus_sup,
   input logic [ADDR_W-1:0] bus_addr,
   input logic [DATA_W-1:0] bus_rdata,
   input logic [DATA_W-1:0] cfg_word,
   input logic              irq_req,
   input logic              irq_ack,
   input logic [LVL_W-1:0]  irq_level,
   input logic [VEC_W-1:0]  irq_vector
);
   logic [3:0] pend;
   logic       rd_stat, cfg_user_rd, cfg_user_wr;
   assign pend        = flags & enables;
   assign rd_stat     = bus_rd && bus_addr == ADDR_W'(0);
   assign cfg_user_rd = bus_rd && !bus_sup && bus_addr == ADDR_W'(2);
   assign cfg_user_wr = bus_wr && !bus_sup && bus_addr == ADDR_W'(2);

   assert_evt_sets_R1: assert property (@(posedge clk) disable iff (!rst_n)
      evt_i != 4'b0 |=> (flags & $past(evt_i)) == $past(evt_i));

   assert_req_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pend != 4'b0 |-> irq_req);

   assert_req_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
      pend == 4'b0 |-> !irq_req);

   assert_unarmed_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (flags & ~armed) != 4'b0 |=> (flags & $past(flags & ~armed)) == $past(flags & ~armed));

   assert_arm_needs_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed & ~$past(armed)) != 4'b0 |-> $past(rd_stat));

   assert_vec_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_ack && irq_req) |-> irq_vector == '0);

   assert_vec_lowest_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_ack && irq_req) |->
         (pend[irq_vector[1:0]] &&
          (pend & ((4'b1 << irq_vector[1:0]) - 4'b1)) == 4'b0));

   assert_lvl_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req |-> irq_level == '0);

   assert_user_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_user_rd |-> bus_rdata == '0);

   assert_user_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_user_wr |=> $stable(cfg_word));

   assert_rsvd_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_rd && bus_addr == ADDR_W'(2)) |-> (bus_rdata & ~CFG_MASK) == '0);
endmodule

bind qdi_irq_ctrl qdi_irq_checker #(
   .DATA_W   (DATA_W),
   .LVL_W    (LVL_W),
   .VEC_W    (VEC_W),
   .ADDR_W   (ADDR_W),
   .CFG_MASK (CFG_MASK)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .evt_i      (evt_i),
   .flags      (flags_q),
   .armed      (armed_q),
   .enables    (enables),
   .bus_rd     (bus_rd),
   .bus_wr     (bus_wr),
   .bus_sup    (bus_sup),
   .bus_addr   (bus_addr),
   .bus_rdata  (bus_rdata),
   .cfg_word   (cfg_word),
   .irq_req    (irq_req),
   .irq_ack    (irq_ack),
   .irq_level  (irq_level),
   .irq_vector (irq_vector)
);

// File: tb/qdi_irq_ctrl_bench.sv
module qdi_irq_ctrl_bench;
   localparam logic [15:0] CFG_MASK = 16'hFC77;

   logic clk = 1'b0;
   always #5 clk = ~clk;

   logic        rst_n;
   logic [3:0]  evt_i;
   logic        bus_rd, bus_wr, bus_sup, irq_ack;
   logic [1:0]  bus_addr;
   logic [15:0] bus_wdata, bus_rdata;
   logic        irq_req;
   logic [2:0]  irq_level;
   logic [7:0]  irq_vector;

   qdi_irq_ctrl u_qdi_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .evt_i(evt_i),
      .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_sup(bus_sup),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .irq_req(irq_req), .irq_level(irq_level), .irq_ack(irq_ack),
      .irq_vector(irq_vector)
   );

   int total = 0;
   int bad   = 0;
   bit done  = 0;

   logic [3:0]  m_flag, m_arm, m_en;
   logic [15:0] m_cfg;
   logic [15:0] last_rd;
   logic        last_req;
   logic [2:0]  last_lvl;
   logic [7:0]  last_vec;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [15:0] exp_rdata(input logic [1:0] ad, input logic sup);
      case (ad)
         2'd0:    return {12'b0, m_flag};
         2'd1:    return {12'b0, m_en};
         2'd2:    return sup ? m_cfg : 16'h0;
         default: return 16'h0;
      endcase
   endfunction

   function automatic logic [1:0] exp_sel();
      logic [1:0] s = 2'd0;
      for (int i = 3; i >= 0; i--)
         if (m_flag[i] && m_en[i]) s = 2'(i);
      return s;
   endfunction

   function automatic logic [2:0] exp_level();
      if ((m_flag & m_en) == 4'b0) return 3'd0;
      return (exp_sel() < 2'd2) ? m_cfg[2:0] : m_cfg[6:4];
   endfunction

   function automatic logic [7:0] exp_vector(input logic ack);
      if (!ack || (m_flag & m_en) == 4'b0) return 8'h0;
      return {m_cfg[15:10], exp_sel()};
   endfunction

   task automatic step(input logic [3:0] ev, input logic rd, input logic wr,
                       input logic [1:0] ad, input logic [15:0] wd,
                       input logic sup, input logic ack);
      logic [3:0] nf, na;
      logic clr;
      @(negedge clk);
      evt_i = ev; bus_rd = rd; bus_wr = wr; bus_addr = ad;
      bus_wdata = wd; bus_sup = sup; irq_ack = ack;
      #1;
      if (rd) begin
         case (ad)
            2'd0: chk("R1 status read", bus_rdata, exp_rdata(ad, sup));
            2'd1: chk("R2 enable read", bus_rdata, exp_rdata(ad, sup));
            2'd2: chk("R8 config read", bus_rdata, exp_rdata(ad, sup));
            default: chk("R9 unused read", bus_rdata, exp_rdata(ad, sup));
         endcase
         last_rd = bus_rdata;
      end
      chk("R2 irq_req", irq_req, (m_flag & m_en) != 4'b0);
      chk("R7 irq_level", irq_level, exp_level());
      chk("R6 irq_vector", irq_vector, exp_vector(ack));
      last_req = irq_req; last_lvl = irq_level; last_vec = irq_vector;
      @(posedge clk);
      for (int i = 0; i < 4; i++) begin
         clr = wr && ad == 2'd0 && !wd[i];
         nf[i] = m_flag[i];
         na[i] = m_arm[i];
         if (ev[i]) begin
            nf[i] = 1'b1;
            na[i] = 1'b0;
         end else begin
            if (clr && m_arm[i]) nf[i] = 1'b0;
            if (rd && ad == 2'd0 && m_flag[i]) na[i] = 1'b1;
            else if (clr && m_arm[i]) na[i] = 1'b0;
         end
      end
      m_flag = nf;
      m_arm  = na;
      if (wr && ad == 2'd1) m_en = wd[3:0];
      if (wr && ad == 2'd2 && sup) m_cfg = wd & CFG_MASK;
   endtask

   task automatic rd_stat();
      step(4'b0, 1'b1, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
   endtask

   task automatic wr_stat(input logic [15:0] wd);
      step(4'b0, 1'b0, 1'b1, 2'd0, wd, 1'b0, 1'b0);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         bad++;
         total++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      int unsigned seed;
      seed = 32'd1357;
      void'($urandom(seed));
      m_flag = '0; m_arm = '0; m_en = '0; m_cfg = '0;
      evt_i = '0; bus_rd = 0; bus_wr = 0; bus_sup = 0; irq_ack = 0;
      bus_addr = '0; bus_wdata = '0;
      rst_n = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;

      // R10: reset state
      rd_stat();
      chk("R10 flags after reset", last_rd, 16'h0);
      chk("R10 irq_req after reset", last_req, 1'b0);
      step(4'b0, 1'b1, 1'b0, 2'd2, 16'h0, 1'b1, 1'b0);
      chk("R10 config after reset", last_rd, 16'h0);

      // R9: reserved bits
      step(4'b0, 1'b0, 1'b1, 2'd2, 16'hFFFF, 1'b1, 1'b0);
      step(4'b0, 1'b1, 1'b0, 2'd2, 16'h0, 1'b1, 1'b0);
      chk("R9 reserved bits read zero", last_rd, 16'hFC77);
      step(4'b0, 1'b1, 1'b0, 2'd3, 16'h0, 1'b1, 1'b0);
      chk("R9 address 3 reads zero", last_rd, 16'h0);

      // configure: base 101101, q2 level 5, q1 level 3
      step(4'b0, 1'b0, 1'b1, 2'd2, 16'hB453, 1'b1, 1'b0);
      step(4'b0, 1'b0, 1'b1, 2'd1, 16'h000F, 1'b0, 1'b0);

      // R8: user-mode access
      step(4'b0, 1'b0, 1'b1, 2'd2, 16'h0000, 1'b0, 1'b0);
      step(4'b0, 1'b1, 1'b0, 2'd2, 16'h0, 1'b0, 1'b0);
      chk("R8 user read is zero", last_rd, 16'h0);
      step(4'b0, 1'b1, 1'b0, 2'd2, 16'h0, 1'b1, 1'b0);
      chk("R8 user write ignored", last_rd, 16'hB453);

      // R1 / R3: set pause flag of queue 1, zero write without read
      step(4'b0010, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      wr_stat(16'h0);
      rd_stat();
      chk("R3 unread flag not cleared", last_rd, 16'h0002);
      step(4'b0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R6 vector queue 1 pause", last_vec, 8'hB5);
      chk("R7 level queue 1", last_lvl, 3'd3);

      // R4: one leaves it set, zero clears
      wr_stat(16'h000F);
      rd_stat();
      chk("R4 writing one keeps flag", last_rd, 16'h0002);
      wr_stat(16'h0);
      rd_stat();
      chk("R4 read then zero clears", last_rd, 16'h0);
      chk("R2 request drops after clear", irq_req, 1'b0);

      // R5: event between read and write
      step(4'b0100, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      rd_stat();
      step(4'b0100, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      wr_stat(16'h0);
      rd_stat();
      chk("R5 event after read keeps flag", last_rd, 16'h0004);
      step(4'b0100, 1'b0, 1'b1, 2'd0, 16'h0, 1'b0, 1'b0);
      rd_stat();
      chk("R5 event with write keeps flag", last_rd, 16'h0004);
      wr_stat(16'h0);
      rd_stat();
      chk("R5 fresh read allows clear", last_rd, 16'h0);

      // R6 / R7: priority and per-queue level
      step(4'b1100, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      step(4'b0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R6 vector queue 2 done first", last_vec, 8'hB6);
      chk("R7 level queue 2", last_lvl, 3'd5);
      step(4'b0001, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      step(4'b0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b1);
      chk("R6 vector queue 1 done wins", last_vec, 8'hB4);
      chk("R7 level follows source", last_lvl, 3'd3);

      // R2: request held; enables gate it
      repeat (3) step(4'b0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      chk("R2 request held while pending", last_req, 1'b1);
      step(4'b0, 1'b0, 1'b1, 2'd1, 16'h0000, 1'b0, 1'b0);
      step(4'b0, 1'b0, 1'b0, 2'd0, 16'h0, 1'b0, 1'b0);
      chk("R2 disabled flags no request", last_req, 1'b0);
      step(4'b0, 1'b0, 1'b1, 2'd1, 16'h000F, 1'b0, 1'b0);
      rd_stat();
      wr_stat(16'h0);
      rd_stat();
      chk("R4 all flags cleared", last_rd, 16'h0);

      // random traffic against the model
      for (int n = 0; n < 3000; n++) begin
         logic [3:0] ev;
         logic [2:0] op;
         ev = '0;
         for (int b = 0; b < 4; b++) ev[b] = ($urandom % 8) == 0;
         op = 3'($urandom % 6);
         step(ev, op < 2, op == 2 || op == 3, 2'($urandom % 4),
              (op == 2) ? 16'h0 : 16'($urandom), 1'($urandom % 2),
              ($urandom % 3) == 0);
      end

      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule